// File: doc/BRIEF.md
# Square-Root Carry-Select Adder

This block adds two 20-bit unsigned operands and a carry-in in one combinational pass. It produces a 20-bit sum and a carry-out. The operand width is cut into five stages whose widths grow by one bit per stage: 2, 3, 4, 5 and 6 bits, starting at the least significant end.

The lowest stage is a plain ripple adder that takes the external carry-in directly. Each higher stage forms its propagate and generate terms once. It then runs two carry chains: one that assumes an incoming carry of 0 and one that assumes an incoming carry of 1. When the real carry from the stage below arrives, a multiplexer picks the matching sum bits and stage carry-out.

Each wider stage has more time to settle its two candidate results while the select carry travels up through the narrower stages below it. A parameter set to zero growth gives equal-width stages instead.

Top module: `sqrt_csel_adder`

## Requirements
- R1: For every pair of operands and every carry-in, {carry_out, sum_out} equals op_a + op_b + carry_in as an unsigned 21-bit value.
- R2: The stage carries enter at bit positions 2, 5, 9 and 14. A carry that ripples through all bits below one of these positions sets that bit of the sum.
- R3: The lowest stage (bits 1..0) uses carry_in directly. With both operands zero, carry_in = 1 gives sum_out = 1 and carry_out = 0.
- R4: In every selecting stage, the candidate that assumes an incoming carry of 1 equals the candidate that assumes 0, plus one. If the 0-candidate produces a carry-out, the 1-candidate does too.
- R5: carry_out is the carry leaving the top stage (bits 19..14). All-ones plus a carry-in of 1 gives sum_out = 0 and carry_out = 1.
- R6: A carry generated at the top bit of one stage is passed into the stage above even when that stage generates nothing itself.
- R7: When no bit generates a carry and carry_in is 0, no carry appears. For example, all-ones plus zero gives all-ones with carry_out = 0.
- R8: For the same operands, raising carry_in from 0 to 1 raises the 21-bit result {carry_out, sum_out} by exactly one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 20 | First addend |
| op_b | input | 20 | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 20 | Sum bits |
| carry_out | output | 1 | Carry out of bit 19 |

## Verification
Two things can happen at once in a selecting stage: the incoming carry chooses the 1-candidate, and the stage generates its own carry internally. The bench provokes this by putting a run of ones below a stage boundary with carry_in = 1, and placing generating bit pairs inside the stage above. Each result is judged against a 21-bit reference sum computed independently in the bench. Walking the boundary and generate patterns across every stage position shows that each select carry arrives at the correct bit.

// File: rtl/sqcs_pkg.sv
// Package sqcs_pkg
// Purpose : shared helpers that place the stages of the carry-select adder.
// Assumes : stage k is FIRST_W + GROW*k bits wide; stage 0 sits at bit 0.
package sqcs_pkg;

    // Width of stage k.
    function automatic int stage_width(input int first_w, input int grow, input int k);
        return first_w + grow * k;
    endfunction

    // Least significant bit of stage k: the sum of the widths below it.
    function automatic int stage_lsb(input int first_w, input int grow, input int k);
        return k * first_w + (grow * k * (k - 1)) / 2;
    endfunction

    // Total adder width for a given stage count.
    function automatic int total_width(input int first_w, input int grow, input int stages);
        return stage_lsb(first_w, grow, stages);
    endfunction

endpackage

// File: rtl/sqcs_carry_chain.sv
// Module sqcs_carry_chain
// Purpose : ripple carry chain over N bits, built from propagate/generate terms.
// Assumes : prop = a ^ b and gen = a & b for each bit; purely combinational.
module sqcs_carry_chain #(
    parameter int N = 4
) (
    input  logic [N-1:0] prop,
    input  logic [N-1:0] gen,
    input  logic         cin,
    output logic [N:0]   carries
);

    // Walk the chain from bit 0 upward: carry[i+1] = g[i] | p[i]&carry[i].
    always_comb begin
        logic [N:0] cv;
        cv[0] = cin;
        for (int i = 0; i < N; i++) begin
            cv[i+1] = gen[i] | (prop[i] & cv[i]);
        end
        carries = cv;
    end

endmodule

// File: rtl/sqcs_base_stage.sv
// Module sqcs_base_stage
// Purpose : lowest adder stage, a plain ripple adder fed by the external carry.
// Assumes : no select multiplexer; its carry-out drives the next stage's select.
module sqcs_base_stage #(
    parameter int N = 2
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         cin,
    output logic [N-1:0] sum,
    output logic         cout
);

    logic [N-1:0] prop;
    logic [N-1:0] gen;
    logic [N:0]   chain;

    // Per-bit propagate and generate terms.
    always_comb begin
        prop = a ^ b;
        gen  = a & b;
    end

    sqcs_carry_chain #(.N(N)) u_chain (
        .prop    (prop),
        .gen     (gen),
        .cin     (cin),
        .carries (chain)
    );

    // Sum bits from propagate and incoming carries; carry-out from the chain top.
    always_comb begin
        sum  = prop ^ chain[N-1:0];
        cout = chain[N];
    end

    // R3
    base_stage_chk: assert final ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{N{1'b0}}, cin}))
        else $error("base stage result differs from a+b+cin");

endmodule

// File: rtl/sqcs_select_stage.sv
// Module sqcs_select_stage
// Purpose : carry-select stage; precomputes results for incoming carry 0 and 1,
//           then the real incoming carry picks one through multiplexers.
// Assumes : propagate/generate are shared; only the carry chain and mux are doubled.
module sqcs_select_stage #(
    parameter int N = 3
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         sel_carry,
    output logic [N-1:0] sum,
    output logic         cout
);

    logic [N-1:0] prop;
    logic [N-1:0] gen;
    logic [N:0]   chain_lo;
    logic [N:0]   chain_hi;
    logic [N-1:0] cand_sum0;
    logic [N-1:0] cand_sum1;
    logic         cand_c0;
    logic         cand_c1;

    // Shared propagate and generate terms.
    always_comb begin
        prop = a ^ b;
        gen  = a & b;
    end

    // Chain that assumes an incoming carry of 0.
    sqcs_carry_chain #(.N(N)) u_chain_lo (
        .prop    (prop),
        .gen     (gen),
        .cin     (1'b0),
        .carries (chain_lo)
    );

    // Chain that assumes an incoming carry of 1.
    sqcs_carry_chain #(.N(N)) u_chain_hi (
        .prop    (prop),
        .gen     (gen),
        .cin     (1'b1),
        .carries (chain_hi)
    );

    // Form both candidate results.
    always_comb begin
        cand_sum0 = prop ^ chain_lo[N-1:0];
        cand_sum1 = prop ^ chain_hi[N-1:0];
        cand_c0   = chain_lo[N];
        cand_c1   = chain_hi[N];
    end

    // Select the candidate matching the real incoming carry.
    always_comb begin
        if (sel_carry) begin
            sum  = cand_sum1;
            cout = cand_c1;
        end else begin
            sum  = cand_sum0;
            cout = cand_c0;
        end
    end

    // R4
    cand_step_chk: assert final ({cand_c1, cand_sum1} == ({cand_c0, cand_sum0} + 1'b1))
        else $error("1-candidate is not 0-candidate plus one");

    // R4
    cand_carry_order_chk: assert final (!(cand_c0 && !cand_c1))
        else $error("0-candidate carries while 1-candidate does not");

endmodule

// File: rtl/sqrt_csel_adder.sv
// Module sqrt_csel_adder
// Purpose : combinational square-root carry-select adder; stage widths grow by
//           GROW bits per stage (default 2,3,4,5,6 for a 20-bit adder).
// Assumes : stage 0 is a ripple adder on carry_in; each later stage is a
//           select stage driven by the carry out of the stage below.
module sqrt_csel_adder #(
    parameter int FIRST_W = 2,
    parameter int STAGES  = 5,
    parameter int GROW    = 1,
    localparam int W      = sqcs_pkg::total_width(FIRST_W, GROW, STAGES)
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         carry_in,
    output logic [W-1:0] sum_out,
    output logic         carry_out
);

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_st
            localparam int SW = sqcs_pkg::stage_width(FIRST_W, GROW, k);
            localparam int LO = sqcs_pkg::stage_lsb(FIRST_W, GROW, k);
            logic          c_in;
            logic          c_out;
            logic [SW-1:0] s;

            if (k == 0) begin : g_base
                // Lowest stage takes the external carry directly.
                always_comb c_in = carry_in;
                sqcs_base_stage #(.N(SW)) u_stage (
                    .a    (op_a[LO +: SW]),
                    .b    (op_b[LO +: SW]),
                    .cin  (c_in),
                    .sum  (s),
                    .cout (c_out)
                );
            end else begin : g_sel
                logic [LO:0] below_ref;
                // Select carry is the carry out of the stage below.
                always_comb c_in = g_st[k-1].c_out;
                sqcs_select_stage #(.N(SW)) u_stage (
                    .a         (op_a[LO +: SW]),
                    .b         (op_b[LO +: SW]),
                    .sel_carry (c_in),
                    .sum       (s),
                    .cout      (c_out)
                );
                // Reference carry into this boundary from the low operand bits.
                always_comb below_ref = {1'b0, op_a[LO-1:0]} + {1'b0, op_b[LO-1:0]}
                                        + {{LO{1'b0}}, carry_in};
                // R2
                boundary_carry_chk: assert final (c_in == below_ref[LO])
                    else $error("stage carry at boundary is wrong");
            end

            // Place this stage's sum bits.
            always_comb sum_out[LO +: SW] = s;
        end
    endgenerate

    // Carry out of the adder is the carry out of the top stage.
    always_comb carry_out = g_st[STAGES-1].c_out;

    // R1
    full_sum_chk: assert final ({carry_out, sum_out} ==
                                ({1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, carry_in}))
        else $error("adder result differs from a+b+cin");

endmodule

// File: tb/sqrt_csel_adder_bench.sv
`timescale 1ns/1ps
module sqrt_csel_adder_bench;

    localparam int W = 20;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         carry_in = 1'b0;
    logic [W-1:0] sum_out;
    logic         carry_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    sqrt_csel_adder u_sqrt_csel_adder (
        .op_a      (op_a),
        .op_b      (op_b),
        .carry_in  (carry_in),
        .sum_out   (sum_out),
        .carry_out (carry_out)
    );

    // 200 MHz clock.
    always #2.5 clk = ~clk;

    // Apply one vector, wait one cycle and compare against the reference sum.
    task automatic apply_check(input logic [W-1:0] a, input logic [W-1:0] b,
                               input logic ci, input string req);
        logic [W:0] expv;
        logic [W:0] got;
        @(negedge clk);
        op_a = a; op_b = b; carry_in = ci;
        @(posedge clk);
        #1;
        expv = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
        got  = {carry_out, sum_out};
        n_checks++;
        if (got !== expv) begin
            n_fail++;
            $display("FAIL %s: a=%h b=%h cin=%b got=%h expected=%h", req, a, b, ci, got, expv);
        end
    endtask

    // Reset state: zero inputs held through reset give a zero result.
    task automatic t_reset;
        repeat (3) @(posedge clk);
        #1;
        n_checks++;
        if ({carry_out, sum_out} !== '0) begin
            n_fail++;
            $display("FAIL R1 reset: got=%h expected=0", {carry_out, sum_out});
        end
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R3: carry_in reaches bit 0 with no stage in front of it.
    task automatic t_cin_only;
        apply_check('0, '0, 1'b1, "R3");
        apply_check(20'h00001, '0, 1'b1, "R3");
        apply_check(20'h00003, '0, 1'b0, "R3");
    endtask

    // R2: carry rippling up to each stage boundary 2,5,9,14.
    task automatic t_boundaries;
        int pos [4] = '{2, 5, 9, 14};
        foreach (pos[i]) begin
            apply_check((20'h1 << pos[i]) - 20'h1, '0, 1'b1, "R2");
            apply_check((20'h1 << pos[i]) - 20'h1, 20'h1, 1'b0, "R2");
        end
    endtask

    // R6: a carry generated at a stage's top bit crosses into the next stage.
    task automatic t_generate_top;
        int pos [4] = '{2, 5, 9, 14};
        foreach (pos[i]) begin
            apply_check(20'h1 << (pos[i] - 1), 20'h1 << (pos[i] - 1), 1'b0, "R6");
        end
    endtask

    // Select and local generate together: ripple below a boundary, generates above it.
    task automatic t_select_and_generate;
        apply_check(20'h001FF | 20'h00600, 20'h00600, 1'b1, "R2");
        apply_check(20'h03FFF | 20'hC0000, 20'hC0000, 1'b1, "R2");
    endtask

    // R5 and R7: all-ones corners.
    task automatic t_all_ones;
        apply_check(20'hFFFFF, '0, 1'b1, "R5");
        apply_check(20'hFFFFF, 20'h00001, 1'b0, "R5");
        apply_check(20'hFFFFF, 20'hFFFFF, 1'b1, "R5");
        apply_check(20'hFFFFF, '0, 1'b0, "R7");
        apply_check(20'hAAAAA, 20'h55555, 1'b0, "R7");
    endtask

    // R8: carry_in step, plus R1 pseudo-random sweep.
    task automatic t_random;
        logic [31:0] lfsr = 32'h1ACE_B00C;
        for (int i = 0; i < 300; i++) begin
            logic [W-1:0] a;
            logic [W-1:0] b;
            logic [W:0] r0;
            logic [W:0] r1;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = lfsr[W-1:0];
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            b = lfsr[W+5:6];
            apply_check(a, b, 1'b0, "R1");
            r0 = {carry_out, sum_out};
            apply_check(a, b, 1'b1, "R1");
            r1 = {carry_out, sum_out};
            n_checks++;
            if (r1 !== r0 + 1'b1) begin
                n_fail++;
                $display("FAIL R8: a=%h b=%h got=%h expected=%h", a, b, r1, r0 + 1'b1);
            end
        end
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_cin_only();
        t_boundaries();
        t_generate_top();
        t_select_and_generate();
        t_all_ones();
        t_random();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule